// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM with 19 address bits. The host issues single-word requests: a request pulse, a read/write flag, an address and, for writes, a data byte. The controller produces the memory's active-low select, write strobe and output enable, the address, and a data output with its own drive enable. It returns read data with a one-cycle completion pulse.

Every phase of the memory sequence lasts a whole number of clock cycles. Each count is computed from a nanosecond limit and the clock period as a parameter, rounded up, and is never less than one cycle. The timing limits are:

- read access and read cycle: 20 ns
- output-enable access: 9 ns
- write pulse and select/address-to-end-of-write: 14 ns
- data setup to end of write: 10 ns
- write cycle: 20 ns
- bus turnaround after the memory stops driving: 9 ns

The controller never drives the shared data lines while the memory's output may still be active.

Top module: `sram_seq`

## Requirements
- R1: Right after reset, select, write strobe and output enable are high, the data driver is off, `hostReady` is 1 and `hostDone` is 0.
- R2: A read holds select low, output enable low and write strobe high without a break for exactly RD = max(ceil(20/T), ceil(9/T)) cycles, where T is `CLK_NS`. The address stays constant during that window.
- R3: `hostRdata` holds the byte present on `memDin` in the last cycle of the read window. `hostDone` is seen RD+1 cycles after the accepting edge.
- R4: A write holds select and write strobe both low for exactly WP = max(ceil(14/T), ceil(10/T)) cycles. Both rise on the same edge, and output enable stays high while the write strobe is low.
- R5: `memDrvEn` is 1 exactly while the write pulse is active. During that time `memDout` equals the host write byte and does not change, so the memory stores that byte at the address given.
- R6: A write completes after W + WP + REC + 1 cycles, where REC = max(0, ceil(20/T) - WP) and W is the turnaround wait from R7.
- R7: After output enable was last low, the data driver turns on only after at least TURN = ceil(9/T) cycles with output enable high. A write accepted j edges after a read ends waits W = max(0, TURN - j) extra cycles.
- R8: `hostReady` falls on acceptance and returns after `hostDone`, which lasts one cycle. A request raised while busy is ignored and starts no memory cycle.
- R9: Whenever `hostReady` is 1, all memory controls are high and the driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request, sampled while ready |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | DATA_W | Write byte |
| hostRdata | output | DATA_W | Captured read byte |
| hostReady | output | 1 | Idle and able to accept |
| hostDone | output | 1 | One-cycle completion pulse |
| memCsN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | DATA_W | Data toward memory |
| memDrvEn | output | 1 | Enable for the data driver |
| memDin | input | DATA_W | Data from memory |

## Verification
The bench builds the design with a 3 ns period setting so that every phase spans several cycles. That gives a 7-cycle read window, a 5-cycle write pulse, 2 recovery cycles and a 3-cycle turnaround. Counting from the accepting edge, completion is expected on the 8th falling edge for a read and on the (W+8)th for a write. W is worked out in the bench from the gap after the preceding read. A memory model in the bench puts valid data on `memDin` only after the full access count has passed, so an early capture reads a poison byte. It also measures pulse and read-window lengths and the output-enable-high run before each driver turn-on, sampling all of them on falling edges.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WTURN,
    ST_WPULSE,
    ST_WREC,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic drvEn;
  } pinCtl_t;

  typedef struct packed {
    logic load;
    logic capture;
  } dpStrobe_t;

  function automatic int nsToCyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC   = 1,
  parameter int WP_CYC   = 1,
  parameter int REC_CYC  = 0,
  parameter int TURN_CYC = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      req,
  input  logic      wrFlag,
  output pinCtl_t   pin,
  output dpStrobe_t strb,
  output logic      ready,
  output logic      done
);

  localparam int CNT_MAX = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(REC_CYC, 1));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TURN_W  = $clog2(TURN_CYC + 1);
  localparam logic [CNT_W-1:0]  RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0]  WP_LOAD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0]  REC_LOAD  = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
  localparam logic [TURN_W-1:0] TURN_LOAD = TURN_W'(TURN_CYC);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [TURN_W-1:0] turnCnt;
  logic turnLoad;
  pinCtl_t pinQ;

  function automatic pinCtl_t pinsFor(input seqState_t s);
    pinCtl_t p;
    p = '{csN: 1'b1, weN: 1'b1, oeN: 1'b1, drvEn: 1'b0};
    case (s)
      ST_RD:     begin p.csN = 1'b0; p.oeN = 1'b0; end
      ST_WPULSE: begin p.csN = 1'b0; p.weN = 1'b0; p.drvEn = 1'b1; end
      default:   ;
    endcase
    return p;
  endfunction

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    turnLoad = 1'b0;
    strb     = '0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          strb.load = 1'b1;
          if (!wrFlag) begin
            stateNxt = ST_RD;
            cntNxt   = RD_LOAD;
          end else if (turnCnt > TURN_W'(1)) begin
            stateNxt = ST_WTURN;
          end else begin
            stateNxt = ST_WPULSE;
            cntNxt   = WP_LOAD;
          end
        end
      end
      ST_RD: begin
        if (cnt == '0) begin
          strb.capture = 1'b1;
          turnLoad     = 1'b1;
          stateNxt     = ST_DONE;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_WTURN: begin
        if (turnCnt <= TURN_W'(1)) begin
          stateNxt = ST_WPULSE;
          cntNxt   = WP_LOAD;
        end
      end
      ST_WPULSE: begin
        if (cnt == '0) begin
          if (REC_CYC > 0) begin
            stateNxt = ST_WREC;
            cntNxt   = REC_LOAD;
          end else begin
            stateNxt = ST_DONE;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_WREC: begin
        if (cnt == '0) stateNxt = ST_DONE;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      turnCnt <= '0;
      pinQ    <= '{csN: 1'b1, weN: 1'b1, oeN: 1'b1, drvEn: 1'b0};
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      pinQ  <= pinsFor(stateNxt);
      if (turnLoad)            turnCnt <= TURN_LOAD;
      else if (turnCnt != '0)  turnCnt <= turnCnt - 1'b1;
    end
  end

  assign pin   = pinQ;
  assign ready = (state == ST_IDLE);
  assign done  = (state == ST_DONE);

  // R4
  wr_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinQ.weN |-> (pinQ.oeN && !pinQ.csN));

  // R7
  drv_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinQ.drvEn) |-> (turnCnt == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && req) |=> !ready);

  // R3
  capture_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (!pinQ.csN && !pinQ.oeN && pinQ.weN));

  // R9
  idle_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (pinQ.csN && pinQ.weN && pinQ.oeN && !pinQ.drvEn));

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  pinCtl_t           pin,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [DATA_W-1:0] hostRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= hostAddr;
        wdataQ <= hostWdata;
      end
      if (strb.capture) rdataQ <= memDin;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign hostRdata = rdataQ;

  // R5
  drv_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pin.drvEn && $past(pin.drvEn)) |-> $stable(memDout));

  // R2
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pin.oeN && $past(!pin.oeN)) |-> $stable(memAddr));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 20,
  parameter int T_AA_NS   = 20,
  parameter int T_OE_NS   = 9,
  parameter int T_WP_NS   = 14,
  parameter int T_CW_NS   = 14,
  parameter int T_DW_NS   = 10,
  parameter int T_WC_NS   = 20,
  parameter int T_TURN_NS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostReady,
  output logic              hostDone,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrvEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int RD_CYC = maxOf(maxOf(nsToCyc(T_RC_NS, CLK_NS), nsToCyc(T_AA_NS, CLK_NS)),
                                nsToCyc(T_OE_NS, CLK_NS));
  localparam int WP_CYC = maxOf(maxOf(nsToCyc(T_WP_NS, CLK_NS), nsToCyc(T_CW_NS, CLK_NS)),
                                nsToCyc(T_DW_NS, CLK_NS));
  localparam int WC_CYC   = nsToCyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC  = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 0;
  localparam int TURN_CYC = nsToCyc(T_TURN_NS, CLK_NS);

  pinCtl_t   pin;
  dpStrobe_t strb;

  sram_seq_ctrl #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .TURN_CYC(TURN_CYC)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .req   (hostReq),
    .wrFlag(hostWrite),
    .pin   (pin),
    .strb  (strb),
    .ready (hostReady),
    .done  (hostDone)
  );

  sram_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pin      (pin),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .hostRdata(hostRdata)
  );

  assign memCsN   = pin.csN;
  assign memWeN   = pin.weN;
  assign memOeN   = pin.oeN;
  assign memDrvEn = pin.drvEn;

endmodule

// File: tb/test_sram_seq.sv
`timescale 1ns/1ps
module test_sram_seq;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int TNS = 3;
  localparam int DEPTH = 1 << AW;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + TNS - 1) / TNS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_NEED   = mx(cyc(20), cyc(9));
  localparam int WP_NEED   = mx(cyc(14), cyc(10));
  localparam int REC_NEED  = (cyc(20) > WP_NEED) ? cyc(20) - WP_NEED : 0;
  localparam int TURN_NEED = cyc(9);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] hostRdata;
  logic hostReady, hostDone;
  logic memCsN, memWeN, memOeN, memDrvEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDout;
  logic [DW-1:0] memDin = 8'hEE;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(TNS)) i_sram_seq (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostReady(hostReady), .hostDone(hostDone),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memAddr(memAddr), .memDout(memDout), .memDrvEn(memDrvEn),
    .memDin(memDin)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model and pin monitor
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] expMem [DEPTH];
  int readRun = 0;
  int pulseLen = 0;
  int oeRun = 255;
  logic prevDrv = 1'b0;
  logic [AW-1:0] lastA, rdAddr;
  logic [DW-1:0] lastD;

  always @(negedge clk) begin
    if (rstN) begin
      // read window
      if (!memCsN && !memOeN && memWeN) begin
        if (readRun > 0 && memAddr != rdAddr)
          check(0, "R2 address changed in read", int'(memAddr), int'(rdAddr));
        rdAddr = memAddr;
        readRun++;
      end else begin
        if (readRun != 0) check(readRun == RD_NEED, "R2 read window length", readRun, RD_NEED);
        readRun = 0;
      end
      memDin = (readRun >= RD_NEED) ? mem[memAddr] : 8'hEE;
      // write pulse
      if (!memCsN && !memWeN) begin
        if (!memOeN) check(0, "R4 oe low during write", 0, 1);
        if (!memDrvEn) check(0, "R5 driver off during pulse", 0, 1);
        if (pulseLen > 0 && memDout != lastD)
          check(0, "R5 data moved in pulse", int'(memDout), int'(lastD));
        pulseLen++;
        lastA = memAddr;
        lastD = memDout;
      end else begin
        if (memDrvEn) check(0, "R5 driver on outside pulse", 1, 0);
        if (pulseLen != 0) begin
          check(pulseLen == WP_NEED, "R4 write pulse length", pulseLen, WP_NEED);
          check(memCsN && memWeN, "R4 select and strobe rise together",
                int'({memCsN, memWeN}), 3);
          mem[lastA] = lastD;
        end
        pulseLen = 0;
      end
      // turnaround
      if (memDrvEn && !prevDrv)
        check(oeRun >= TURN_NEED, "R7 turnaround before drive", oeRun, TURN_NEED);
      if (!memOeN) oeRun = 0;
      else if (!memDrvEn && oeRun < 255) oeRun++;
      prevDrv = memDrvEn;
      // idle controls
      if (hostReady && !(memCsN && memWeN && memOeN && !memDrvEn))
        check(0, "R9 controls not idle while ready", 0, 1);
    end
  end

  task automatic doOp(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int gap, input bit prevRead, input bit intrude);
    int n;
    int w;
    int expLat;
    repeat (gap) @(negedge clk);
    check(hostReady == 1'b1, "R8 ready before request", int'(hostReady), 1);
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 1'b0;
    n = 1;
    check(hostReady == 1'b0, "R8 ready low after acceptance", int'(hostReady), 0);
    while (!hostDone && n < 60) begin
      if (intrude && n == 3) begin
        hostReq = 1'b1; hostWrite = 1'b1; hostAddr = a ^ 6'd1; hostWdata = ~d;
      end else begin
        hostReq = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    hostReq = 1'b0;
    if (wr) begin
      w = prevRead ? mx(0, TURN_NEED - 2 - gap) : 0;
      expLat = w + WP_NEED + REC_NEED + 1;
      check(n == expLat, "R6 write completion cycle", n, expLat);
      expMem[a] = d;
    end else begin
      expLat = RD_NEED + 1;
      check(n == expLat, "R3 read completion cycle", n, expLat);
      check(hostRdata == expMem[a], "R3 read data", int'(hostRdata), int'(expMem[a]));
    end
    check(hostReady == 1'b0, "R8 ready low during done", int'(hostReady), 0);
    @(negedge clk);
    check(hostDone == 1'b0, "R8 done one cycle", int'(hostDone), 0);
    check(hostReady == 1'b1, "R8 ready back after done", int'(hostReady), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'h00;
      expMem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(memCsN && memWeN && memOeN, "R1 controls high in reset",
          int'({memCsN, memWeN, memOeN}), 7);
    check(!memDrvEn, "R1 driver off in reset", int'(memDrvEn), 0);
    check(hostReady && !hostDone, "R1 ready/done in reset", int'({hostReady, hostDone}), 2);
    rstN = 1'b1;
    @(negedge clk);
    check(hostReady == 1'b1, "R1 ready after reset", int'(hostReady), 1);

    // fill every address (writes back-to-back)
    for (int a = 0; a < DEPTH; a++)
      doOp(1'b1, AW'(a), DW'((a * 37 + 5) & 8'hFF), 0, 1'b0, 1'b0);
    // read back, then write-after-read with varied gaps, then read again
    for (int a = 0; a < DEPTH; a++) begin
      doOp(1'b0, AW'(a), 8'h00, a % 3, 1'b0, 1'b0);
      doOp(1'b1, AW'(a), DW'(~((a * 37 + 5) & 8'hFF)), a % 4, 1'b1, 1'b0);
      doOp(1'b0, AW'(a), 8'h00, 0, 1'b0, 1'b0);
    end
    // consecutive reads with no gap
    for (int a = 0; a < 8; a++) doOp(1'b0, AW'(a * 5), 8'h00, 0, 1'b0, 1'b0);

    // R8: request while busy is ignored
    doOp(1'b0, 6'd10, 8'h00, 0, 1'b0, 1'b1);
    begin
      int act;
      act = 0;
      for (int k = 0; k < 8; k++) begin
        if (!memCsN) act++;
        @(negedge clk);
      end
      check(act == 0, "R8 no cycle from busy request", act, 0);
    end
    doOp(1'b0, 6'd11, 8'h00, 0, 1'b0, 1'b0);
    doOp(1'b1, 6'd20, 8'hA5, 0, 1'b1, 1'b1);
    repeat (8) @(negedge clk);
    doOp(1'b0, 6'd21, 8'h00, 0, 1'b0, 1'b0);
    doOp(1'b0, 6'd20, 8'h00, 0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule